// File: doc/BRIEF.md
# Hardwired Control Step Unit

This block is the sequencing heart of a small processor whose registers, ALU and memory interface share one internal bus. Each cycle it looks at the current control step, the instruction held in the datapath's instruction register, the negative condition flag and the memory-complete handshake. From these it produces the full set of gate, ALU and memory control lines for that cycle. Everything is fixed logic: a step register, a one-hot opcode decoder and a per-step encoder.

The step register moves through the enumerated states `S_T1` to `S_T7`. The transitions are:
- **advance**: to the next step at each clock edge while the run condition holds.
- **stall**: hold the current step while a wait-for-memory step sees no completion.
- **finish**: go back to `S_T1` at the edge after any step that raises the end line. This starts a new fetch.
- **reset**: an asynchronous return to `S_T1`.

Steps `S_T1` to `S_T3` are the fetch, which is the same for every instruction. Steps `S_T4` onward depend on the decoded opcode. There are four opcodes:
- an add of a register and a memory word addressed by another register, with the result written back;
- an unconditional relative branch;
- a branch taken only when the negative flag is set;
- a no-operation code.

Top module: `hw_ctrl_unit`

## Requirements
- R1: While reset is low, and in the first cycle after reset is released, the unit is in step 1. In that step exactly these outputs are high: pc_out, mar_in, mem_read, sel_four, alu_add and z_in.
- R2: Fetch runs in three steps.
  - Step 1 is the set given in R1.
  - Step 2 raises exactly z_out, pc_in, y_in and wmfc.
  - Step 3 raises exactly mdr_out and ir_in.
- R3: A step that raises wmfc is held, with identical outputs, for every clock edge at which mfc is 0. The unit leaves that step at the first edge where mfc is 1.
- R4: Opcode ir_op=2'b00 adds the register selected by ir_dst to the memory word addressed by the register selected by ir_src, and writes the sum to the ir_dst register.
  - Register k maps to bit k of reg_in and reg_out.
  - Step 4: reg_out[src], mar_in, mem_read.
  - Step 5: reg_out[dst], y_in, wmfc.
  - Step 6: mdr_out, alu_add, z_in, with sel_four low.
  - Step 7: z_out, reg_in[dst], end_o.
- R5: Opcode 2'b01 is an unconditional branch.
  - Step 4: ir_ofs_out, alu_add, z_in.
  - Step 5: z_out, pc_in, end_o.
- R6: Opcode 2'b10 with flag_n=0 raises ir_ofs_out, alu_add, z_in and end_o in step 4. The next cycle is fetch step 1.
- R7: Opcode 2'b10 with flag_n=1 gives the same step 4 as R6 but without end_o. It then runs step 5 with z_out, pc_in and end_o.
- R8: The cycle after any step that raises end_o is fetch step 1.
- R9: In every step, at most one of pc_out, mdr_out, ir_ofs_out, z_out and the reg_out bits is high.
- R10: Opcode 2'b11 raises only end_o in step 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ir_op | input | 2 | Opcode field of the instruction register |
| ir_dst | input | RW | Destination register index |
| ir_src | input | RW | Source (address) register index |
| flag_n | input | 1 | Negative condition flag |
| mfc | input | 1 | Memory operation complete |
| reg_in | output | NREG | Load gates of the general registers |
| reg_out | output | NREG | Bus drive gates of the general registers |
| pc_out | output | 1 | PC drives bus |
| pc_in | output | 1 | PC loads from bus |
| mar_in | output | 1 | Address register loads from bus |
| mdr_out | output | 1 | Data register drives bus |
| ir_in | output | 1 | Instruction register loads |
| ir_ofs_out | output | 1 | Branch offset field drives bus |
| y_in | output | 1 | ALU operand latch loads |
| z_in | output | 1 | ALU result latch loads |
| z_out | output | 1 | ALU result latch drives bus |
| sel_four | output | 1 | ALU A input takes constant four (else Y) |
| alu_add | output | 1 | ALU adds |
| mem_read | output | 1 | Start memory read |
| mem_write | output | 1 | Start memory write (unused by this opcode set, held low) |
| wmfc | output | 1 | Wait for memory complete |
| end_o | output | 1 | Last step of the instruction |

## Verification
The bench holds the memory handshake low for several cycles in both wait steps. A design that let the step counter run on would show step 3 or step 6 signals too early, or would drop the wait.

It drives the conditional branch with the flag clear and with it set. Ending only at step 5, or never ending at step 4, shows up as a wrong end_o or a missing return to fetch.

It runs the add with two different register pairs, so swapped or mis-decoded register fields appear on reg_in and reg_out. It also checks every sampled step for two bus drivers at once.

// File: rtl/hwctl_pkg.sv
package hwctl_pkg;

    localparam int OPW  = 2;
    localparam int NOPS = 1 << OPW;

    localparam int OP_ADD  = 0;
    localparam int OP_BR   = 1;
    localparam int OP_BRN  = 2;
    localparam int OP_NONE = 3;

    typedef enum logic [2:0] {
        S_T1 = 3'd0,
        S_T2 = 3'd1,
        S_T3 = 3'd2,
        S_T4 = 3'd3,
        S_T5 = 3'd4,
        S_T6 = 3'd5,
        S_T7 = 3'd6
    } step_t;

    typedef struct packed {
        logic pc_out;
        logic pc_in;
        logic mar_in;
        logic mdr_out;
        logic ir_in;
        logic ofs_out;
        logic y_in;
        logic z_in;
        logic z_out;
        logic sel_four;
        logic alu_add;
        logic mem_read;
        logic mem_write;
        logic wmfc;
        logic end_step;
        logic src_out;
        logic dst_out;
        logic dst_in;
    } ctl_t;

endpackage

// File: rtl/step_counter.sv
module step_counter
    import hwctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run,
    input  logic  end_step,
    output step_t step
);

    step_t step_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) step <= S_T1;
        else        step <= step_nxt;
    end

    always_comb begin
        step_nxt = step;
        if (end_step) begin
            step_nxt = S_T1;
        end else if (run) begin
            unique case (step)
                S_T1:    step_nxt = S_T2;
                S_T2:    step_nxt = S_T3;
                S_T3:    step_nxt = S_T4;
                S_T4:    step_nxt = S_T5;
                S_T5:    step_nxt = S_T6;
                S_T6:    step_nxt = S_T7;
                S_T7:    step_nxt = S_T7;
                default: step_nxt = S_T1;
            endcase
        end
    end

endmodule

// File: rtl/ins_decoder.sv
module ins_decoder
    import hwctl_pkg::*;
(
    input  logic [OPW-1:0]  op,
    output logic [NOPS-1:0] ins
);

    for (genvar i = 0; i < NOPS; i++) begin : g_line
        assign ins[i] = (op == OPW'(i));
    end

endmodule

// File: rtl/reg_gate.sv
module reg_gate #(
    parameter int NREG = 4,
    localparam int RW  = $clog2(NREG)
) (
    input  logic [RW-1:0]   idx,
    input  logic            en,
    output logic [NREG-1:0] gate
);

    for (genvar k = 0; k < NREG; k++) begin : g_bit
        assign gate[k] = en && (idx == RW'(k));
    end

endmodule

// File: rtl/step_encoder.sv
module step_encoder
    import hwctl_pkg::*;
(
    input  step_t           step,
    input  logic [NOPS-1:0] ins,
    input  logic            flag_n,
    output ctl_t            ctl
);

    always_comb begin
        ctl = '0;
        unique case (step)
            S_T1: begin
                ctl.pc_out   = 1'b1;
                ctl.mar_in   = 1'b1;
                ctl.mem_read = 1'b1;
                ctl.sel_four = 1'b1;
                ctl.alu_add  = 1'b1;
                ctl.z_in     = 1'b1;
            end
            S_T2: begin
                ctl.z_out = 1'b1;
                ctl.pc_in = 1'b1;
                ctl.y_in  = 1'b1;
                ctl.wmfc  = 1'b1;
            end
            S_T3: begin
                ctl.mdr_out = 1'b1;
                ctl.ir_in   = 1'b1;
            end
            S_T4: begin
                if (ins[OP_ADD]) begin
                    ctl.src_out  = 1'b1;
                    ctl.mar_in   = 1'b1;
                    ctl.mem_read = 1'b1;
                end else if (ins[OP_BR] || ins[OP_BRN]) begin
                    ctl.ofs_out  = 1'b1;
                    ctl.alu_add  = 1'b1;
                    ctl.z_in     = 1'b1;
                    ctl.end_step = ins[OP_BRN] && !flag_n;
                end else begin
                    ctl.end_step = 1'b1;
                end
            end
            S_T5: begin
                if (ins[OP_ADD]) begin
                    ctl.dst_out = 1'b1;
                    ctl.y_in    = 1'b1;
                    ctl.wmfc    = 1'b1;
                end else begin
                    ctl.z_out    = 1'b1;
                    ctl.pc_in    = 1'b1;
                    ctl.end_step = 1'b1;
                end
            end
            S_T6: begin
                ctl.mdr_out = 1'b1;
                ctl.alu_add = 1'b1;
                ctl.z_in    = 1'b1;
            end
            S_T7: begin
                ctl.z_out    = 1'b1;
                ctl.dst_in   = 1'b1;
                ctl.end_step = 1'b1;
            end
            default: ctl.end_step = 1'b1;
        endcase
    end

endmodule

// File: rtl/hw_ctrl_unit.sv
module hw_ctrl_unit
    import hwctl_pkg::*;
#(
    parameter int NREG = 4,
    localparam int RW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OPW-1:0]  ir_op,
    input  logic [RW-1:0]   ir_dst,
    input  logic [RW-1:0]   ir_src,
    input  logic            flag_n,
    input  logic            mfc,
    output logic [NREG-1:0] reg_in,
    output logic [NREG-1:0] reg_out,
    output logic            pc_out,
    output logic            pc_in,
    output logic            mar_in,
    output logic            mdr_out,
    output logic            ir_in,
    output logic            ir_ofs_out,
    output logic            y_in,
    output logic            z_in,
    output logic            z_out,
    output logic            sel_four,
    output logic            alu_add,
    output logic            mem_read,
    output logic            mem_write,
    output logic            wmfc,
    output logic            end_o
);

    step_t           step;
    logic [NOPS-1:0] ins;
    ctl_t            ctl;
    logic            run;
    logic [NREG-1:0] src_gate;
    logic [NREG-1:0] dst_gate;

    // stall while waiting on memory
    assign run = !(ctl.wmfc && !mfc);

    step_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .end_step (ctl.end_step),
        .step     (step)
    );

    ins_decoder u_dec (
        .op  (ir_op),
        .ins (ins)
    );

    step_encoder u_enc (
        .step   (step),
        .ins    (ins),
        .flag_n (flag_n),
        .ctl    (ctl)
    );

    reg_gate #(.NREG(NREG)) u_src (
        .idx  (ir_src),
        .en   (ctl.src_out),
        .gate (src_gate)
    );

    reg_gate #(.NREG(NREG)) u_dsto (
        .idx  (ir_dst),
        .en   (ctl.dst_out),
        .gate (dst_gate)
    );

    reg_gate #(.NREG(NREG)) u_dsti (
        .idx  (ir_dst),
        .en   (ctl.dst_in),
        .gate (reg_in)
    );

    assign reg_out    = src_gate | dst_gate;
    assign pc_out     = ctl.pc_out;
    assign pc_in      = ctl.pc_in;
    assign mar_in     = ctl.mar_in;
    assign mdr_out    = ctl.mdr_out;
    assign ir_in      = ctl.ir_in;
    assign ir_ofs_out = ctl.ofs_out;
    assign y_in       = ctl.y_in;
    assign z_in       = ctl.z_in;
    assign z_out      = ctl.z_out;
    assign sel_four   = ctl.sel_four;
    assign alu_add    = ctl.alu_add;
    assign mem_read   = ctl.mem_read;
    assign mem_write  = ctl.mem_write;
    assign wmfc       = ctl.wmfc;
    assign end_o      = ctl.end_step;

endmodule

// File: rtl/hw_ctrl_unit_chk.sv
module hw_ctrl_unit_chk #(
    parameter int NREG = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mfc,
    input logic [NREG-1:0] reg_out,
    input logic            pc_out,
    input logic            pc_in,
    input logic            mar_in,
    input logic            mdr_out,
    input logic            ir_in,
    input logic            ir_ofs_out,
    input logic            y_in,
    input logic            z_out,
    input logic            sel_four,
    input logic            mem_read,
    input logic            wmfc,
    input logic            end_o
);

    // R9
    one_bus_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones({pc_out, mdr_out, ir_ofs_out, z_out, reg_out}) <= 1));

    // R3
    wmfc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wmfc && !mfc) |=> wmfc);

    // R8
    end_refetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_o |=> (pc_out && mar_in && mem_read && sel_four));

    // R2
    fetch_t2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_out && sel_four) |=> (z_out && pc_in && y_in && wmfc));

    // R2
    fetch_t3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_in && wmfc && mfc) |=> (mdr_out && ir_in));

endmodule

bind hw_ctrl_unit hw_ctrl_unit_chk #(.NREG(NREG)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mfc        (mfc),
    .reg_out    (reg_out),
    .pc_out     (pc_out),
    .pc_in      (pc_in),
    .mar_in     (mar_in),
    .mdr_out    (mdr_out),
    .ir_in      (ir_in),
    .ir_ofs_out (ir_ofs_out),
    .y_in       (y_in),
    .z_out      (z_out),
    .sel_four   (sel_four),
    .mem_read   (mem_read),
    .wmfc       (wmfc),
    .end_o      (end_o)
);

// File: tb/hw_ctrl_unit_bench.sv
`timescale 1ns/1ps
module hw_ctrl_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ir_op = 2'b11;
    logic [1:0] ir_dst = '0;
    logic [1:0] ir_src = '0;
    logic       flag_n = 1'b0;
    logic       mfc = 1'b0;
    logic [3:0] reg_in, reg_out;
    logic pc_out, pc_in, mar_in, mdr_out, ir_in, ir_ofs_out, y_in, z_in, z_out;
    logic sel_four, alu_add, mem_read, mem_write, wmfc, end_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    hw_ctrl_unit u_hw_ctrl_unit (
        .clk(clk), .rst_n(rst_n), .ir_op(ir_op), .ir_dst(ir_dst), .ir_src(ir_src),
        .flag_n(flag_n), .mfc(mfc), .reg_in(reg_in), .reg_out(reg_out),
        .pc_out(pc_out), .pc_in(pc_in), .mar_in(mar_in), .mdr_out(mdr_out),
        .ir_in(ir_in), .ir_ofs_out(ir_ofs_out), .y_in(y_in), .z_in(z_in),
        .z_out(z_out), .sel_four(sel_four), .alu_add(alu_add), .mem_read(mem_read),
        .mem_write(mem_write), .wmfc(wmfc), .end_o(end_o)
    );

    localparam logic [22:0] M_PCO = 23'(1) << 22;
    localparam logic [22:0] M_PCI = 23'(1) << 21;
    localparam logic [22:0] M_MAR = 23'(1) << 20;
    localparam logic [22:0] M_MDO = 23'(1) << 19;
    localparam logic [22:0] M_IRI = 23'(1) << 18;
    localparam logic [22:0] M_OFS = 23'(1) << 17;
    localparam logic [22:0] M_YI  = 23'(1) << 16;
    localparam logic [22:0] M_ZI  = 23'(1) << 15;
    localparam logic [22:0] M_ZO  = 23'(1) << 14;
    localparam logic [22:0] M_S4  = 23'(1) << 13;
    localparam logic [22:0] M_ADD = 23'(1) << 12;
    localparam logic [22:0] M_RD  = 23'(1) << 11;
    localparam logic [22:0] M_WF  = 23'(1) << 9;
    localparam logic [22:0] M_END = 23'(1) << 8;

    localparam logic [22:0] F1 = M_PCO | M_MAR | M_RD | M_S4 | M_ADD | M_ZI;
    localparam logic [22:0] F2 = M_ZO | M_PCI | M_YI | M_WF;
    localparam logic [22:0] F3 = M_MDO | M_IRI;

    function automatic logic [22:0] rin(int k);
        return 23'(1) << (4 + k);
    endfunction

    function automatic logic [22:0] rout(int k);
        return 23'(1) << k;
    endfunction

    task automatic go();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic [22:0] exp, input string tag);
        logic [22:0] obs;
        #1;
        obs = {pc_out, pc_in, mar_in, mdr_out, ir_in, ir_ofs_out, y_in, z_in, z_out,
               sel_four, alu_add, mem_read, mem_write, wmfc, end_o, reg_in, reg_out};
        n_chk++;
        if (obs !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, obs, exp);
        end
        // R9 single bus source on every sampled step
        n_chk++;
        if ($countones({pc_out, mdr_out, ir_ofs_out, z_out, reg_out}) > 1) begin
            n_bad++;
            $display("FAIL R9 (%s): bus sources got %0d expected <=1", tag,
                     $countones({pc_out, mdr_out, ir_ofs_out, z_out, reg_out}));
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(F1, "R1 in reset");
        rst_n = 1'b1;
        go();
        chk(F2, "R1 first step after release then step 2");
        mfc = 1'b1;
        go();
        mfc = 1'b0;
        chk(F3, "R2 step 3");
        ir_op = 2'b11;
        go();
        chk(M_END, "R10 no-op step 4");
        go();
        chk(F1, "R8 back to step 1");
    endtask

    task automatic t_fetch(input int stall);
        chk(F1, "R2 step 1");
        go();
        chk(F2, "R2 step 2");
        for (int i = 0; i < stall; i++) begin
            go();
            chk(F2, "R3 stalled step 2");
        end
        mfc = 1'b1;
        chk(F2, "R3 step 2 with mfc");
        go();
        mfc = 1'b0;
        chk(F3, "R2 step 3");
        go();
    endtask

    task automatic t_add(input int d, input int s);
        ir_op = 2'b00; ir_dst = 2'(d); ir_src = 2'(s);
        t_fetch(2);
        chk(rout(s) | M_MAR | M_RD, "R4 step 4");
        go();
        chk(rout(d) | M_YI | M_WF, "R4 step 5");
        go();
        chk(rout(d) | M_YI | M_WF, "R3 stalled step 5");
        go();
        chk(rout(d) | M_YI | M_WF, "R3 stalled step 5 again");
        mfc = 1'b1;
        go();
        mfc = 1'b0;
        chk(M_MDO | M_ADD | M_ZI, "R4 step 6");
        go();
        chk(M_ZO | rin(d) | M_END, "R4 step 7");
        go();
        chk(F1, "R8 after add");
    endtask

    task automatic t_br(input logic n);
        ir_op = 2'b01; flag_n = n;
        t_fetch(0);
        chk(M_OFS | M_ADD | M_ZI, "R5 step 4");
        go();
        chk(M_ZO | M_PCI | M_END, "R5 step 5");
        go();
        chk(F1, "R8 after branch");
    endtask

    task automatic t_brn(input logic n);
        ir_op = 2'b10; flag_n = n;
        t_fetch(1);
        if (!n) begin
            chk(M_OFS | M_ADD | M_ZI | M_END, "R6 step 4 ends");
            go();
            chk(F1, "R6 refetch after step 4");
        end else begin
            chk(M_OFS | M_ADD | M_ZI, "R7 step 4 continues");
            go();
            chk(M_ZO | M_PCI | M_END, "R7 step 5 loads PC");
            go();
            chk(F1, "R8 after taken branch");
        end
    endtask

    task automatic t_none();
        ir_op = 2'b11;
        t_fetch(0);
        chk(M_END, "R10 no-op step 4");
        go();
        chk(F1, "R8 after no-op");
    endtask

    initial begin
        #150000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_add(2, 1);
        t_add(0, 3);
        t_br(1'b0);
        t_br(1'b1);
        t_brn(1'b0);
        t_brn(1'b1);
        t_none();
        t_add(3, 3);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule